// File: doc/BRIEF.md
# Load/Store Alignment Fault Checker

This block judges every load or store issued at the most privileged execution level and decides whether it must raise an alignment fault. Three separate tests run on each request. The first is an element-size test: the address must be a multiple of the access size. The second is a stack-pointer test: when the base register is the stack pointer, the address must be 16-byte aligned. The third is a containment test for one class of instructions: all accessed bytes must fall inside a single 16-byte-aligned block. Each test has its own enable. The verdict comes out one clock after the request, together with a valid flag.

The verdict is reported in two ways. Two flags separate a stack-pointer alignment fault from an alignment fault that is delivered as a data abort. A 2-bit kind code names the test that failed. When several tests fail at once, a fixed priority picks one result. Exception delivery happens downstream and is not part of this block.

Top module: `align_fault_checker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `rsp_vld`, `rsp_align_flt` and `rsp_sp_flt` at 0 and `rsp_kind` at 0.
- R2: `rsp_vld` is 1 exactly one cycle after a cycle with `req_vld` high. When `rsp_vld` is 0, both fault flags are 0 and `rsp_kind` is 0.
- R3: When `cfg_align_en` is 1 or `req_always_chk` is 1, an address that is not a multiple of the access size fails the element test.
- R4: When `cfg_align_en` and `req_always_chk` are both 0, the element test never fails, whatever the address.
- R5: When `cfg_sp_chk_en` and `req_sp_base` are both 1, an address whose low 4 bits are not zero raises the stack-pointer fault: `rsp_sp_flt`=1 and `rsp_kind`=3.
- R6: When `req_blk_cls` is 1 and `cfg_unalign_ok` is 0, a request fails the containment test if (address mod 16) + size is greater than 16.
- R7: When `cfg_unalign_ok` is 1, the containment test never fails.
- R8: Only one result is reported, chosen by priority. A stack-pointer failure gives kind 3, `rsp_sp_flt`=1 and `rsp_align_flt`=0. Otherwise an element failure gives kind 1. Otherwise a containment failure gives kind 2. Otherwise the kind is 0. `rsp_align_flt` is 1 exactly for kinds 1 and 2.
- R9: `req_size` is log2 of the access size in bytes (0=1, 1=2, 2=4, 3=8, 4=16). Codes 5 to 7 are treated as 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Effective address |
| req_size | input | 3 | log2 of the access size in bytes |
| req_sp_base | input | 1 | Base register is the stack pointer |
| req_blk_cls | input | 1 | Instruction belongs to the class covered by the containment test |
| req_always_chk | input | 1 | Instruction keeps its element test even when alignment checking is off |
| cfg_align_en | input | 1 | Element-size alignment checking enable |
| cfg_sp_chk_en | input | 1 | Stack-pointer alignment checking enable |
| cfg_unalign_ok | input | 1 | 1 waives the containment test |
| rsp_vld | output | 1 | Verdict valid |
| rsp_align_flt | output | 1 | Alignment fault, delivered as a data abort |
| rsp_sp_flt | output | 1 | Stack-pointer alignment fault |
| rsp_kind | output | 2 | 0 none, 1 element, 2 containment, 3 stack pointer |

## Verification
The bench aims at the boundary of the containment test. An 8-byte access at offset 8 ends exactly on the block edge and must pass; the same access at offset 12 must fail. A design that used `>=` instead of `>` would fault on the first case. The bench also sets several tests failing at once. A design with the wrong priority would report a data abort where a stack-pointer fault is due, or a containment kind where an element kind is due. Size codes 5 to 7 and the always-checked flag with alignment checking off are driven as well. A design that mishandled them would miss faults on 16-byte element boundaries, or skip the element test on instructions that must always be checked.

// File: rtl/afc_pkg.sv
// Package: shared fault-kind encoding for the alignment fault checker.
// Assumes: kind codes are decoded by the exception logic downstream.
package afc_pkg;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_ELEM  = 2'd1,
        FK_BLOCK = 2'd2,
        FK_STACK = 2'd3
    } fault_kind_e;

endpackage

// File: rtl/afc_elem_check.sv
// Element-size alignment test.
// Does: flags an address that is not a multiple of 2**size_eff, when enabled.
// Assumes: size_eff is already clamped to MAX_LOG2.
module afc_elem_check #(
    parameter int SZ_W     = 3,
    parameter int MAX_LOG2 = 4
) (
    input  logic [MAX_LOG2-1:0] addr_lo,
    input  logic [SZ_W-1:0]     size_eff,
    input  logic                chk_en,
    output logic                fail
);

    logic [MAX_LOG2-1:0] low_mask;

    // Build the mask of address bits that must be zero for this size.
    for (genvar i = 0; i < MAX_LOG2; i++) begin : g_mask
        assign low_mask[i] = (size_eff > SZ_W'(i));
    end

    // Fail when the test is enabled and any masked bit is set.
    always_comb begin
        fail = chk_en && (|(addr_lo & low_mask));
    end

endmodule

// File: rtl/afc_sp_check.sv
// Stack-pointer alignment test.
// Does: flags a stack-pointer-based access whose address is not 2**SP_LOG2 aligned.
// Assumes: the enable and the stack-pointer flag arrive with the address.
module afc_sp_check #(
    parameter int SP_LOG2 = 4
) (
    input  logic [SP_LOG2-1:0] addr_lo,
    input  logic               sp_base,
    input  logic               chk_en,
    output logic               fail
);

    // Fail on any set low bit when the test applies.
    always_comb begin
        fail = chk_en && sp_base && (|addr_lo);
    end

endmodule

// File: rtl/afc_block_check.sv
// Block containment test.
// Does: flags an access of the covered class that crosses a 2**BLK_LOG2 boundary.
// Assumes: size_eff <= BLK_LOG2, so offset + span fits in BLK_LOG2+2 bits.
module afc_block_check #(
    parameter int SZ_W     = 3,
    parameter int BLK_LOG2 = 4
) (
    input  logic [BLK_LOG2-1:0] addr_lo,
    input  logic [SZ_W-1:0]     size_eff,
    input  logic                blk_cls,
    input  logic                waive,
    output logic                fail
);

    localparam int SUM_W = BLK_LOG2 + 2;
    localparam logic [SUM_W-1:0] BLK_BYTES = SUM_W'(1) << BLK_LOG2;

    logic [SUM_W-1:0] span;
    logic [SUM_W-1:0] end_pos;

    // Compute the end offset of the access inside its block.
    always_comb begin
        span    = SUM_W'(1) << size_eff;
        end_pos = {2'b00, addr_lo} + span;
    end

    // Fail when the access runs past the block and is not waived.
    always_comb begin
        fail = blk_cls && !waive && (end_pos > BLK_BYTES);
    end

endmodule

// File: rtl/afc_resp_stage.sv
// Response stage.
// Does: merges the three test results by priority and registers the verdict.
// Assumes: synchronous active-low reset; verdict is cleared when no request.
module afc_resp_stage
    import afc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic        sp_fail,
    input  logic        elem_fail,
    input  logic        block_fail,
    output logic        out_vld,
    output logic        out_align,
    output logic        out_sp,
    output logic [1:0]  out_kind
);

    fault_kind_e kind_d;
    fault_kind_e kind_q;
    logic        vld_q;

    // Pick one result: stack pointer, then element, then containment.
    always_comb begin
        if (sp_fail) begin
            kind_d = FK_STACK;
        end else if (elem_fail) begin
            kind_d = FK_ELEM;
        end else if (block_fail) begin
            kind_d = FK_BLOCK;
        end else begin
            kind_d = FK_NONE;
        end
    end

    // Register the verdict one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            kind_q <= FK_NONE;
        end else begin
            vld_q  <= in_vld;
            kind_q <= in_vld ? kind_d : FK_NONE;
        end
    end

    // Decode the registered kind into the two fault flags.
    always_comb begin
        out_vld   = vld_q;
        out_kind  = kind_q;
        out_align = (kind_q == FK_ELEM) || (kind_q == FK_BLOCK);
        out_sp    = (kind_q == FK_STACK);
    end

endmodule

// File: rtl/align_fault_checker.sv
// Top level: alignment fault checker for the most privileged level.
// Does: runs the element, stack-pointer and containment tests on each request
//       and reports one prioritised verdict a cycle later.
// Assumes: MAX_LOG2 <= BLK_LOG2 and SP_LOG2 <= BLK_LOG2 <= ADDR_W.
module align_fault_checker #(
    parameter int ADDR_W   = 64,
    parameter int SZ_W     = 3,
    parameter int MAX_LOG2 = 4,
    parameter int SP_LOG2  = 4,
    parameter int BLK_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic              req_sp_base,
    input  logic              req_blk_cls,
    input  logic              req_always_chk,
    input  logic              cfg_align_en,
    input  logic              cfg_sp_chk_en,
    input  logic              cfg_unalign_ok,
    output logic              rsp_vld,
    output logic              rsp_align_flt,
    output logic              rsp_sp_flt,
    output logic [1:0]        rsp_kind
);

    logic [SZ_W-1:0] size_eff;
    logic            elem_fail;
    logic            sp_fail;
    logic            block_fail;
    logic            addr_hi_unused;

    // Clamp oversize codes to the largest supported access.
    always_comb begin
        size_eff = (req_size > SZ_W'(MAX_LOG2)) ? SZ_W'(MAX_LOG2) : req_size;
    end

    // Upper address bits play no part in any test.
    assign addr_hi_unused = ^req_addr[ADDR_W-1:BLK_LOG2];

    afc_elem_check #(
        .SZ_W     (SZ_W),
        .MAX_LOG2 (MAX_LOG2)
    ) u_elem (
        .addr_lo  (req_addr[MAX_LOG2-1:0]),
        .size_eff (size_eff),
        .chk_en   (cfg_align_en | req_always_chk),
        .fail     (elem_fail)
    );

    afc_sp_check #(
        .SP_LOG2 (SP_LOG2)
    ) u_sp (
        .addr_lo (req_addr[SP_LOG2-1:0]),
        .sp_base (req_sp_base),
        .chk_en  (cfg_sp_chk_en),
        .fail    (sp_fail)
    );

    afc_block_check #(
        .SZ_W     (SZ_W),
        .BLK_LOG2 (BLK_LOG2)
    ) u_blk (
        .addr_lo  (req_addr[BLK_LOG2-1:0]),
        .size_eff (size_eff),
        .blk_cls  (req_blk_cls),
        .waive    (cfg_unalign_ok),
        .fail     (block_fail)
    );

    afc_resp_stage u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (req_vld),
        .sp_fail    (sp_fail),
        .elem_fail  (elem_fail),
        .block_fail (block_fail),
        .out_vld    (rsp_vld),
        .out_align  (rsp_align_flt),
        .out_sp     (rsp_sp_flt),
        .out_kind   (rsp_kind)
    );

endmodule

// File: rtl/align_fault_checker_chk.sv
// Checker: temporal properties of the alignment fault checker, bound to the top.
// Assumes: port names match the top module.
module align_fault_checker_chk #(
    parameter int ADDR_W = 64,
    parameter int SZ_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic [ADDR_W-1:0] req_addr,
    input logic [SZ_W-1:0]   req_size,
    input logic              req_sp_base,
    input logic              req_blk_cls,
    input logic              req_always_chk,
    input logic              cfg_align_en,
    input logic              cfg_sp_chk_en,
    input logic              cfg_unalign_ok,
    input logic              rsp_vld,
    input logic              rsp_align_flt,
    input logic              rsp_sp_flt,
    input logic [1:0]        rsp_kind
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!rsp_vld && !rsp_align_flt && !rsp_sp_flt && rsp_kind == 2'd0)); // R1

    AST_VLD_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld); // R2

    AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> (!rsp_align_flt && !rsp_sp_flt && rsp_kind == 2'd0)); // R2

    AST_SP_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cfg_sp_chk_en && req_sp_base && req_addr[3:0] != 4'd0)
        |=> (rsp_sp_flt && !rsp_align_flt && rsp_kind == 2'd3)); // R5

    AST_NO_FAULT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !cfg_align_en && !req_always_chk && !cfg_sp_chk_en
         && (cfg_unalign_ok || !req_blk_cls))
        |=> (!rsp_align_flt && !rsp_sp_flt)); // R4

    AST_WAIVE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cfg_unalign_ok) |=> (rsp_kind != 2'd2)); // R7

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_align_flt, rsp_sp_flt})); // R8

    AST_ALIGN_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_align_flt |-> (rsp_kind == 2'd1 || rsp_kind == 2'd2)); // R8

endmodule

bind align_fault_checker align_fault_checker_chk #(
    .ADDR_W (ADDR_W),
    .SZ_W   (SZ_W)
) u_chk (.*);

// File: tb/align_fault_checker_test.sv
module align_fault_checker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [63:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic        req_sp_base = 1'b0;
    logic        req_blk_cls = 1'b0;
    logic        req_always_chk = 1'b0;
    logic        cfg_align_en = 1'b0;
    logic        cfg_sp_chk_en = 1'b0;
    logic        cfg_unalign_ok = 1'b0;
    logic        rsp_vld;
    logic        rsp_align_flt;
    logic        rsp_sp_flt;
    logic [1:0]  rsp_kind;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    align_fault_checker uut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
        .req_size(req_size), .req_sp_base(req_sp_base), .req_blk_cls(req_blk_cls),
        .req_always_chk(req_always_chk), .cfg_align_en(cfg_align_en),
        .cfg_sp_chk_en(cfg_sp_chk_en), .cfg_unalign_ok(cfg_unalign_ok),
        .rsp_vld(rsp_vld), .rsp_align_flt(rsp_align_flt), .rsp_sp_flt(rsp_sp_flt),
        .rsp_kind(rsp_kind)
    );

    // Reference model built from the requirements.
    function automatic logic [1:0] model_kind(input logic [63:0] a, input logic [2:0] sz,
                                              input bit sp, input bit cls, input bit alw,
                                              input bit en_a, input bit en_sa, input bit ok);
        int bytes = (sz > 3'd4) ? 16 : (1 << sz);
        int off   = int'(a[3:0]);
        bit e_f   = (en_a || alw) && ((off % bytes) != 0);
        bit s_f   = en_sa && sp && (off != 0);
        bit b_f   = cls && !ok && ((off + bytes) > 16);
        if (s_f) return 2'd3;
        if (e_f) return 2'd1;
        if (b_f) return 2'd2;
        return 2'd0;
    endfunction

    task automatic compare(input string tag, input logic [4:0] got, input logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got vld/align/sp/kind=%b expected %b", tag, got, exp);
        end
    endtask

    // Issue one request at a falling edge, check the verdict one cycle later.
    task automatic issue(input string tag, input logic [63:0] a, input logic [2:0] sz,
                         input bit sp, input bit cls, input bit alw,
                         input bit en_a, input bit en_sa, input bit ok);
        logic [1:0] k;
        req_vld = 1'b1; req_addr = a; req_size = sz; req_sp_base = sp;
        req_blk_cls = cls; req_always_chk = alw; cfg_align_en = en_a;
        cfg_sp_chk_en = en_sa; cfg_unalign_ok = ok;
        k = model_kind(a, sz, sp, cls, alw, en_a, en_sa, ok);
        @(negedge clk);
        compare(tag, {rsp_vld, rsp_align_flt, rsp_sp_flt, rsp_kind},
                {1'b1, (k == 2'd1 || k == 2'd2), (k == 2'd3), k});
    endtask

    task automatic idle(input string tag);
        req_vld = 1'b0;
        req_addr = 64'h7;
        req_size = 3'd3;
        cfg_align_en = 1'b1;
        @(negedge clk);
        compare(tag, {rsp_vld, rsp_align_flt, rsp_sp_flt, rsp_kind}, 5'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        req_vld = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset holds the verdict cleared even with a request present
        compare("R1 reset", {rsp_vld, rsp_align_flt, rsp_sp_flt, rsp_kind}, 5'b0);
        req_vld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle("R2 idle after reset");

        // R3: element test with A on
        issue("R3 8B at +4", 64'h1004, 3'd3, 0, 0, 0, 1, 0, 0);
        issue("R3 8B at +8", 64'h1008, 3'd3, 0, 0, 0, 1, 0, 0);
        issue("R3 2B at +1", 64'hFFFF_0001, 3'd1, 0, 0, 0, 1, 0, 0);
        // R4: element test off unless always-checked
        issue("R4 A off", 64'h1004, 3'd3, 0, 0, 0, 0, 0, 0);
        issue("R3 always-checked", 64'h1004, 3'd3, 0, 0, 1, 0, 0, 0);
        // R5: stack-pointer test
        issue("R5 sp +8", 64'h2008, 3'd0, 1, 0, 0, 0, 1, 0);
        issue("R5 not sp", 64'h2008, 3'd0, 0, 0, 0, 0, 1, 0);
        issue("R5 sp aligned", 64'h2010, 3'd3, 1, 0, 0, 0, 1, 0);
        // R6: containment boundary
        issue("R6 cross at +12", 64'h300C, 3'd3, 0, 1, 0, 0, 0, 0);
        issue("R6 exact end at +8", 64'h3008, 3'd3, 0, 1, 0, 0, 0, 0);
        // R7: waived containment
        issue("R7 waived", 64'h300C, 3'd3, 0, 1, 0, 0, 0, 1);
        // R8: priorities
        issue("R8 sp over all", 64'h400C, 3'd3, 1, 1, 0, 1, 1, 0);
        issue("R8 elem over block", 64'h400C, 3'd3, 0, 1, 0, 1, 0, 0);
        // R9: oversize codes act as 16 bytes
        issue("R9 code7 at +16", 64'h5010, 3'd7, 0, 0, 0, 1, 0, 0);
        issue("R9 code7 at +8", 64'h5018, 3'd7, 0, 0, 0, 1, 0, 0);
        issue("R9 code5 cross", 64'h5001, 3'd5, 0, 1, 0, 0, 0, 0);
        issue("R9 16B aligned", 64'h5020, 3'd4, 0, 1, 0, 1, 0, 0);
        idle("R2 idle between");

        // Random mix, with occasional idle cycles (R2..R9)
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] a;
            a = {$urandom, $urandom};
            if ($urandom % 3 == 0) a[3:0] = 4'h0;
            if ($urandom % 10 == 0) begin
                idle("R2 random idle");
            end else begin
                issue("R8 random", a, 3'($urandom % 8), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule